// File: doc/BRIEF.md
# Single-Clock FIFO with Switchable Standard / Fall-Through Flag Timing

This block is a synchronous first-in first-out buffer of 36-bit words with a power-of-two depth. A single clock drives both sides, and a write and a read may be taken on the same edge. When master reset is applied, the block samples a small configuration. The configuration picks the read behaviour and says how the two threshold offsets are obtained.

In standard timing, a read strobe moves the head word onto `dout` at the edge that takes the strobe. The two status outputs then mean "empty" and "full". In fall-through timing, the head word is moved onto `dout` without a strobe. A read strobe then only retires the word already shown. In this mode the status outputs mean "output ready" and "input ready".

Almost-empty and almost-full outputs compare the occupancy with two offsets. The offsets come from a preset code, from two parallel strobes, or from a serial bit stream. Partial reset empties the buffer but keeps the configuration. Retransmit rewinds the read side to the first word written since the last reset.

Top module: `sfifo_flagmode`

## Requirements
- R1: After master reset the buffer is empty. In standard mode `rd_flag`=1 (empty) and `wr_flag`=0 (full). In fall-through mode `rd_flag`=0 (output ready) and, once the offsets are loaded, `wr_flag`=1 (input ready).
- R2: In standard mode, a `rd_en` taken while the buffer holds data places the oldest word on `dout` at that same edge. Words leave in the order they were written.
- R3: A write while the memory holds 2^AW words is dropped. A standard-mode read while empty is dropped and leaves `dout` unchanged. Neither moves a pointer.
- R4: In fall-through mode, a word written into an empty buffer appears on `dout` with `rd_flag`=1 after the second rising edge, counting the edge that takes the write. A `rd_en` while `rd_flag`=1 retires that word and shows the next one at the same edge. `rd_flag` stays high until the last word is retired.
- R5: `almost_empty` is 1 when the stored count is at or below the empty offset. In fall-through mode the word held on `dout` counts as stored. `almost_full` is 1 when 2^AW minus the memory count is at or below the full offset.
- R6: `cfg_load`=0 or 3 selects preset offsets. `cfg_preset` codes 0,1,2,3 give 8,16,64,256 words, and codes 4 to 7 give 1024. Both offsets take this value, clipped to 2^AW-1.
- R7: `cfg_load`=1 selects parallel loading. The first `ld_stb` after master reset loads the empty offset from `ld_data`, and the second loads the full offset. Writes are dropped until the second strobe.
- R8: `cfg_load`=2 selects serial loading. 2*AW bits are shifted in on `ser_bit` while `ser_en`=1: the empty offset first, then the full offset, each most significant bit first. Writes are dropped until the last bit.
- R9: `prst` empties the buffer and clears the fall-through output stage. It keeps the timing mode and both offsets.
- R10: `retx` sets the read side back to the first word written since the last reset, so that data is read again. Writes and reads presented in the same cycle are dropped. The rewind is valid while no more than 2^AW words were written since that reset.
- R11: A write and a read on the same edge are both taken when each is allowed, and the count is unchanged.
- R12: The timing mode, load method and preset code are captured on every edge where `mrst`=1. They are ignored at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| mrst | input | 1 | Synchronous master reset, active high; captures configuration |
| prst | input | 1 | Synchronous partial reset, active high; keeps configuration |
| retx | input | 1 | Retransmit request, one-cycle pulse |
| cfg_fwft | input | 1 | Timing select captured at master reset: 1 fall-through, 0 standard |
| cfg_load | input | 2 | Offset source captured at master reset: 0/3 preset, 1 parallel, 2 serial |
| cfg_preset | input | 3 | Preset offset code captured at master reset |
| ld_stb | input | 1 | Parallel offset load strobe |
| ld_data | input | AW | Parallel offset value |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data |
| rd_en | input | 1 | Read request |
| dout | output | DW | Read data / head word |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| almost_empty | output | 1 | Occupancy at or below empty offset |
| almost_full | output | 1 | Free space at or below full offset |

## Verification
The assertions rely on these conditions for the inputs:
- Configuration inputs have settled whenever `mrst` is high.
- `retx` is used only while the words written since the last reset fit in the memory, so that the rewound count never exceeds the depth.
- Outside loading, `ld_stb` and `ser_en` stay low.

The stimulus applies master reset for two edges with constant configuration. It pulses `retx` only after a handful of writes in a 32-deep instance. It raises the load strobes only in the window before the offsets are complete.

// File: rtl/sff_pkg.sv
package sff_pkg;

  typedef enum logic [1:0] {
    LD_PRESET = 2'd0,
    LD_PAR    = 2'd1,
    LD_SER    = 2'd2,
    LD_ALT    = 2'd3
  } ld_mode_e;

  // preset offset in words for a 3-bit code
  function automatic int unsigned preset_words(input logic [2:0] code);
    case (code)
      3'd0:    return 32'd8;
      3'd1:    return 32'd16;
      3'd2:    return 32'd64;
      3'd3:    return 32'd256;
      default: return 32'd1024;
    endcase
  endfunction

  // threshold compare shared by both almost flags
  function automatic logic at_or_below(input int unsigned val, input int unsigned thr);
    return val <= thr;
  endfunction

  // occupancy seen by the almost-empty flag
  function automatic int unsigned level_of(input int unsigned mem_cnt, input logic held);
    return mem_cnt + (held ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/sff_cfg.sv
module sff_cfg
  import sff_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          cfg_fwft,
  input  logic [1:0]    cfg_load,
  input  logic [2:0]    cfg_preset,
  input  logic          ld_stb,
  input  logic [AW-1:0] ld_data,
  input  logic          ser_en,
  input  logic          ser_bit,
  output logic          fwft,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic          load_done
);
  localparam int SW = 2 * AW;
  localparam int CW = $clog2(SW + 1);
  localparam int unsigned OMAX = (32'd1 << AW) - 32'd1;

  ld_mode_e      mode_q;
  logic          par_second;
  logic [SW-1:0] shreg;
  logic [CW-1:0] ser_cnt;
  logic [AW-1:0] preset_off;
  logic          ser_last;

  always_comb begin
    int unsigned pv;
    pv = preset_words(cfg_preset);
    if (pv > OMAX) pv = OMAX;
    preset_off = pv[AW-1:0];
  end

  assign ser_last = (ser_cnt == CW'(SW - 1));

  always_ff @(posedge clk) begin
    if (mrst) begin
      fwft       <= cfg_fwft;
      mode_q     <= ld_mode_e'(cfg_load);
      par_second <= 1'b0;
      ser_cnt    <= '0;
      shreg      <= '0;
      if (cfg_load == LD_PAR || cfg_load == LD_SER) begin
        ae_off    <= '0;
        af_off    <= '0;
        load_done <= 1'b0;
      end else begin
        ae_off    <= preset_off;
        af_off    <= preset_off;
        load_done <= 1'b1;
      end
    end else if (!load_done) begin
      if (mode_q == LD_PAR && ld_stb) begin
        if (!par_second) begin
          ae_off     <= ld_data;
          par_second <= 1'b1;
        end else begin
          af_off    <= ld_data;
          load_done <= 1'b1;
        end
      end
      if (mode_q == LD_SER && ser_en) begin
        shreg   <= {shreg[SW-2:0], ser_bit};
        ser_cnt <= ser_cnt + 1'b1;
        if (ser_last) begin
          ae_off    <= shreg[SW-2:AW-1];
          af_off    <= {shreg[AW-2:0], ser_bit};
          load_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sff_store.sv
module sff_store #(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          retx,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [AW:0]   count,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   rd_ptr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (retx)     rd_ptr <= '0;
      else if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mrst)     dout <= '0;
    else if (pop) dout <= mem[rd_ptr[AW-1:0]];
  end

  assign count = wr_ptr - rd_ptr;

endmodule

// File: rtl/sff_flags.sv
module sff_flags
  import sff_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          retx,
  input  logic          fwft,
  input  logic          load_done,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW:0]   count,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic          push,
  output logic          pop,
  output logic          ovalid,
  output logic          mem_full,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic mem_empty;
  logic quiet;
  logic [AW:0] free_cnt;

  assign mem_empty = (count == '0);
  assign mem_full  = (count == DEPTH_V);
  assign quiet     = retx || prst;
  assign free_cnt  = DEPTH_V - count;

  assign push = wr_en && !mem_full && load_done && !quiet;
  assign pop  = !quiet && !mem_empty && (fwft ? (!ovalid || rd_en) : rd_en);

  always_ff @(posedge clk) begin
    if (mrst || prst || retx) ovalid <= 1'b0;
    else if (fwft) begin
      if (pop)        ovalid <= 1'b1;
      else if (rd_en) ovalid <= 1'b0;
    end
  end

  assign rd_flag = fwft ? ovalid : mem_empty;
  assign wr_flag = fwft ? (!mem_full && load_done) : mem_full;

  assign almost_empty = at_or_below(level_of(32'(count), fwft && ovalid), 32'(ae_off));
  assign almost_full  = at_or_below(32'(free_cnt), 32'(af_off));

endmodule

// File: rtl/sfifo_flagmode.sv
module sfifo_flagmode
  import sff_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          retx,
  input  logic          cfg_fwft,
  input  logic [1:0]    cfg_load,
  input  logic [2:0]    cfg_preset,
  input  logic          ld_stb,
  input  logic [AW-1:0] ld_data,
  input  logic          ser_en,
  input  logic          ser_bit,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          almost_empty,
  output logic          almost_full
);
  logic          fwft;
  logic          load_done;
  logic [AW-1:0] ae_off;
  logic [AW-1:0] af_off;
  logic          push;
  logic          pop;
  logic          ovalid;
  logic          mem_full;
  logic [AW:0]   count;
  logic [AW:0]   wr_ptr;
  logic [AW:0]   rd_ptr;

  sff_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .mrst(mrst), .cfg_fwft(cfg_fwft), .cfg_load(cfg_load),
    .cfg_preset(cfg_preset), .ld_stb(ld_stb), .ld_data(ld_data),
    .ser_en(ser_en), .ser_bit(ser_bit), .fwft(fwft), .ae_off(ae_off),
    .af_off(af_off), .load_done(load_done)
  );

  sff_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .mrst(mrst), .prst(prst), .retx(retx), .push(push), .pop(pop),
    .din(din), .dout(dout), .count(count), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  sff_flags #(.AW(AW)) u_flags (
    .clk(clk), .mrst(mrst), .prst(prst), .retx(retx), .fwft(fwft),
    .load_done(load_done), .wr_en(wr_en), .rd_en(rd_en), .count(count),
    .ae_off(ae_off), .af_off(af_off), .push(push), .pop(pop), .ovalid(ovalid),
    .mem_full(mem_full), .rd_flag(rd_flag), .wr_flag(wr_flag),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int AW = 11
) (
  input logic        clk,
  input logic        mrst,
  input logic        prst,
  input logic        retx,
  input logic        fwft,
  input logic        load_done,
  input logic        mem_full,
  input logic        ovalid,
  input logic        pop,
  input logic [AW:0] count,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr
);
  localparam int DEPTH = 1 << AW;

  // R3: stored count never exceeds the memory depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (mrst)
    32'(count) <= DEPTH);

  // R3: a full memory keeps its write pointer
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (mrst)
    (mem_full && !prst) |=> wr_ptr == $past(wr_ptr));

  // R3: an empty memory keeps its read pointer
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (mrst)
    (count == '0 && !prst && !retx) |=> rd_ptr == $past(rd_ptr));

  // R4: fall-through stage fills as soon as memory holds data
  p_fwft_fill_r4: assert property (@(posedge clk) disable iff (mrst)
    (fwft && !ovalid && count != '0 && !prst && !retx) |=> ovalid);

  // R4: standard mode never raises the fall-through stage
  p_std_no_stage_r4: assert property (@(posedge clk) disable iff (mrst)
    !fwft |=> !ovalid);

  // R7 / R8: no write lands before the offsets are complete
  p_load_block_r7: assert property (@(posedge clk) disable iff (mrst)
    (!load_done && !prst) |=> wr_ptr == $past(wr_ptr));

  // R10: retransmit rewinds the read side
  p_rewind_r10: assert property (@(posedge clk) disable iff (mrst)
    (retx && !prst) |=> rd_ptr == '0);

  // R9: partial reset leaves the timing mode alone
  p_keep_mode_r9: assert property (@(posedge clk) disable iff (mrst)
    prst |=> $stable(fwft));

  // R2: a pop never happens from an empty memory
  p_pop_legal_r2: assert property (@(posedge clk) disable iff (mrst)
    pop |-> count != '0);

endmodule

bind sfifo_flagmode sff_checker #(.AW(AW)) u_chk (
  .clk(clk), .mrst(mrst), .prst(prst), .retx(retx), .fwft(fwft),
  .load_done(load_done), .mem_full(mem_full), .ovalid(ovalid), .pop(pop),
  .count(count), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/sfifo_flagmode_test.sv
`timescale 1ns/1ps
module sfifo_flagmode_test;
  localparam int DW = 36;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          mrst = 1'b1, prst = 1'b0, retx = 1'b0;
  logic          cfg_fwft = 1'b0;
  logic [1:0]    cfg_load = 2'd0;
  logic [2:0]    cfg_preset = 3'd0;
  logic          ld_stb = 1'b0;
  logic [AW-1:0] ld_data = '0;
  logic          ser_en = 1'b0, ser_bit = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          rd_flag, wr_flag, almost_empty, almost_full;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sfifo_flagmode #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .mrst(mrst), .prst(prst), .retx(retx), .cfg_fwft(cfg_fwft),
    .cfg_load(cfg_load), .cfg_preset(cfg_preset), .ld_stb(ld_stb),
    .ld_data(ld_data), .ser_en(ser_en), .ser_bit(ser_bit), .wr_en(wr_en),
    .din(din), .rd_en(rd_en), .dout(dout), .rd_flag(rd_flag),
    .wr_flag(wr_flag), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return {4'hC, 32'(i) * 32'h9E37 + 32'h55};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_mrst(input logic fw, input logic [1:0] ld, input logic [2:0] pr);
    mrst = 1'b1; cfg_fwft = fw; cfg_load = ld; cfg_preset = pr;
    step(); step();
    mrst = 1'b0;
    cfg_fwft = ~fw; cfg_load = 2'd0; cfg_preset = 3'd7;  // R12: ignored after reset
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; din = d; step(); wr_en = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic pulse_prst();
    prst = 1'b1; step(); prst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // ---------------- standard mode, preset offset 8 ----------------
    do_mrst(1'b0, 2'd0, 3'd0);
    chk("R1 empty", rd_flag, 1);
    chk("R1 full", wr_flag, 0);
    chk("R1 ae", almost_empty, 1);
    chk("R1 af", almost_full, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      wr(pat(k - 1));
      chk("R5 ae sweep", almost_empty, (k <= 8));
      chk("R5 af sweep", almost_full, (DEPTH - k <= 8));
    end
    chk("R3 full flag", wr_flag, 1);
    chk("R12 mode kept std", rd_flag, 0);
    wr(pat(999));                       // R3: dropped
    for (int k = 0; k < DEPTH; k++) begin
      rd();
      chk("R2 order", dout, pat(k));
    end
    chk("R3 empty after drain", rd_flag, 1);
    rd();
    chk("R3 read empty ignored", dout, pat(DEPTH - 1));

    // R11 simultaneous write and read
    wr(pat(100));
    wr_en = 1'b1; din = pat(101); rd_en = 1'b1; step(); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 dout", dout, pat(100));
    chk("R11 count kept", rd_flag, 0);
    rd();
    chk("R11 second", dout, pat(101));
    chk("R11 empty", rd_flag, 1);

    // R9 partial reset keeps offset 8
    for (int k = 0; k < 3; k++) wr(pat(200 + k));
    pulse_prst();
    chk("R9 cleared", rd_flag, 1);
    for (int k = 1; k <= 9; k++) begin
      wr(pat(300 + k));
      if (k == 8) chk("R9 ae offset kept", almost_empty, 1);
    end
    chk("R9 ae above offset", almost_empty, 0);

    // R10 retransmit
    pulse_prst();
    for (int k = 0; k < 5; k++) wr(pat(400 + k));
    for (int k = 0; k < 3; k++) rd();
    chk("R10 before rewind", dout, pat(402));
    retx = 1'b1; wr_en = 1'b1; din = pat(777); step(); retx = 1'b0; wr_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      rd();
      chk("R10 reread", dout, pat(400 + k));
    end
    chk("R10 write in rewind dropped", rd_flag, 1);

    // ---------------- preset sweep ----------------
    for (int c = 0; c < 6; c++) begin
      int thr;
      thr = (c == 0) ? 8 : (c == 1) ? 16 : DEPTH - 1;
      do_mrst(1'b0, (c == 5) ? 2'd3 : 2'd0, 3'(c));
      for (int k = 0; k < thr; k++) wr(pat(k));
      chk("R6 ae at thr", almost_empty, 1);
      wr(pat(thr));
      chk("R6 ae above thr", almost_empty, 0);
      chk("R6 af", almost_full, (DEPTH - (thr + 1) <= thr));
    end

    // ---------------- parallel load ----------------
    do_mrst(1'b0, 2'd1, 3'd0);
    wr(pat(1));
    chk("R7 write blocked", rd_flag, 1);
    ld_data = 5'd3; ld_stb = 1'b1; step(); ld_stb = 1'b0;
    wr(pat(2));
    chk("R7 still blocked", rd_flag, 1);
    ld_data = 5'd5; ld_stb = 1'b1; step(); ld_stb = 1'b0;
    for (int k = 1; k <= 27; k++) begin
      wr(pat(k));
      if (k == 3)  chk("R7 ae at 3", almost_empty, 1);
      if (k == 4)  chk("R7 ae at 4", almost_empty, 0);
      if (k == 26) chk("R7 af at 26", almost_full, 0);
    end
    chk("R7 af at 27", almost_full, 1);

    // ---------------- serial load ----------------
    do_mrst(1'b0, 2'd2, 3'd0);
    begin
      logic [2*AW-1:0] v;
      v = {5'd2, 5'd4};
      for (int b = 2 * AW - 1; b >= 0; b--) begin
        ser_en = 1'b1; ser_bit = v[b]; step();
        ser_en = 1'b0;
        if (b == AW) begin
          wr(pat(1));
          chk("R8 write blocked", rd_flag, 1);
        end
      end
    end
    for (int k = 1; k <= 28; k++) begin
      wr(pat(k));
      if (k == 2)  chk("R8 ae at 2", almost_empty, 1);
      if (k == 3)  chk("R8 ae at 3", almost_empty, 0);
      if (k == 27) chk("R8 af at 27", almost_full, 0);
    end
    chk("R8 af at 28", almost_full, 1);

    // ---------------- fall-through mode, preset 16 ----------------
    do_mrst(1'b1, 2'd0, 3'd1);
    chk("R1 fwft not ready", rd_flag, 0);
    chk("R1 fwft input ready", wr_flag, 1);
    wr(pat(0));
    chk("R4 one edge", rd_flag, 0);
    step();
    chk("R4 two edges", rd_flag, 1);
    chk("R4 head", dout, pat(0));
    chk("R5 ae fwft", almost_empty, 1);
    for (int k = 1; k <= DEPTH; k++) wr(pat(k));
    chk("R4 input not ready", wr_flag, 0);
    chk("R5 af fwft", almost_full, 1);
    chk("R5 ae fwft full", almost_empty, 0);
    wr(pat(888));                       // R3: dropped
    for (int k = 0; k <= DEPTH; k++) begin
      chk("R4 ready", rd_flag, 1);
      chk("R4 order", dout, pat(k));
      rd();
    end
    chk("R4 drained", rd_flag, 0);

    // R9 in fall-through: mode kept
    wr(pat(50)); wr(pat(51));
    pulse_prst();
    chk("R9 fwft cleared", rd_flag, 0);
    wr(pat(60));
    chk("R9 fwft one edge", rd_flag, 0);
    step();
    chk("R9 fwft mode kept", rd_flag, 1);
    chk("R9 fwft head", dout, pat(60));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule